// File: doc/BRIEF.md
# Byte-Serial AES-128 Encryption Core

This block encrypts one 128-bit block under a 128-bit key using a datapath only one byte wide. A 32-entry byte register file holds the cipher state in one half and the working key in the other. A control sequencer walks that storage one byte per clock through the initial key addition, ten rounds and an on-the-fly key expansion. A single substitution unit, a single XOR unit and a MixColumns unit that yields one byte of a column per cycle are shared by every step. The byte rotation of each state row has no hardware of its own. It comes from the order in which bytes are read back into a four-byte staging buffer.

Key and plaintext bytes arrive over an 8-bit input with a valid strobe and a select line. After `start`, the core stays busy for a fixed number of cycles and then streams the 16 ciphertext bytes on an 8-bit output. The key is expanded in place, so the register file ends an encryption holding the last round key rather than the loaded key.

Top module: `aes8_enc_core`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `dout_valid` are all 0.
- R2: While idle, each cycle with `din_valid`=1 stores `din` as the next byte: key bytes when `key_sel`=1, plaintext bytes when `key_sel`=0. Each select has its own byte counter that starts at byte 0, wraps after byte 15 and returns to 0 when `start` is accepted. Byte n is the n-th byte of the standard big-endian block string, which is state row n mod 4, column n div 4.
- R3: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff, the output is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R4: For any key and plaintext, the output equals AES-128 encryption of that plaintext under that key.
- R5: While `busy`=1, `din_valid`, `din`, `key_sel` and `start` have no effect on the result in progress or on the next load. `busy` goes to 1 in the cycle after `start` is accepted.
- R6: The ciphertext appears as 16 consecutive cycles of `dout_valid`=1, byte 0 first. `done` pulses for one cycle together with byte 15, and `busy` falls in that same cycle.
- R7: The first `dout_valid` appears exactly 945 clock edges after the edge that accepts `start`.
- R8: The working key is replaced by the tenth round key. Starting again without reloading the key encrypts the new plaintext under that round key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an encryption (accepted only while idle) |
| din | input | 8 | Load byte |
| din_valid | input | 1 | Load strobe for `din` |
| key_sel | input | 1 | 1 selects the key half, 0 the plaintext half |
| dout | output | 8 | Ciphertext byte |
| dout_valid | output | 1 | `dout` holds a ciphertext byte |
| busy | output | 1 | Encryption or output stream in progress |
| done | output | 1 | One-cycle pulse with the last ciphertext byte |

## Verification
The case hardest to reach from the ports is the one where the register file starts an encryption holding a key left over from the previous run, not a freshly loaded one. The bench reaches it by starting a second encryption without reloading the key and predicting the result from the tenth round key of its own model. It also floods the load, select and start inputs with random values for the whole busy window, then runs a clean encryption to show that neither the result nor the load counters were disturbed.

// File: rtl/aes8_pkg.sv
package aes8_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARK,
    PH_KEY,
    PH_SUB,
    PH_MIX,
    PH_OUT
  } phase_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] aa;
    p  = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xtime(aa);
    end
    return p;
  endfunction

  // Inverse as x^254 (product of x^2 .. x^128), then the affine map.
  function automatic logic [7:0] sbox_calc(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] inv;
    sq  = x;
    inv = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^
           {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes8_regfile.sv
module aes8_regfile #(
  parameter int W     = 8,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [W-1:0]  rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_b
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // R2: every write lands on a defined address
  a_r2_write_addr_known: assert property (@(posedge clk) we |-> !$isunknown(waddr));

endmodule

// File: rtl/aes8_sbox.sv
module aes8_sbox
  import aes8_pkg::*;
(
  input  logic [7:0] x,
  output logic [7:0] y
);
  assign y = sbox_calc(x);
endmodule

// File: rtl/aes8_mixbyte.sv
module aes8_mixbyte
  import aes8_pkg::*;
(
  input  logic [31:0] col,
  input  logic [1:0]  row,
  output logic [7:0]  y
);
  logic [1:0] i1, i2, i3;
  logic [7:0] b0, b1, b2, b3;

  assign i1 = row + 2'd1;
  assign i2 = row + 2'd2;
  assign i3 = row + 2'd3;
  assign b0 = col[8*row +: 8];
  assign b1 = col[8*i1 +: 8];
  assign b2 = col[8*i2 +: 8];
  assign b3 = col[8*i3 +: 8];
  assign y  = xtime(b0) ^ xtime(b1) ^ b1 ^ b2 ^ b3;
endmodule

// File: rtl/aes8_enc_core.sv
module aes8_enc_core
  import aes8_pkg::*;
#(
  parameter int BYTES  = 16,
  parameter int ROUNDS = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       din_valid,
  input  logic       key_sel,
  output logic [7:0] dout,
  output logic       dout_valid,
  output logic       busy,
  output logic       done
);

  localparam int AW = $clog2(2 * BYTES);
  localparam int IW = $clog2(BYTES);
  localparam int RW = $clog2(ROUNDS + 1);
  localparam logic [RW-1:0] LAST_RND = RW'(ROUNDS);

  phase_t        phase;
  logic [4:0]    cnt;
  logic [RW-1:0] rnd;
  logic [7:0]    rcon;
  logic [IW-1:0] ptr_key, ptr_dat, ptr_sel;
  logic [31:0]   col_q;

  logic          we;
  logic [AW-1:0] wa, ra, rb;
  logic [7:0]    wd, rd_a, rd_b, sb_in, sb_out, opb, xo, mix_out;
  logic [1:0]    grp, jj;
  logic          half;

  assign grp  = cnt[4:3];
  assign half = cnt[2];
  assign jj   = cnt[1:0];
  assign ptr_sel = key_sel ? ptr_key : ptr_dat;
  assign xo   = rd_a ^ opb;

  aes8_regfile #(.W(8), .DEPTH(2 * BYTES)) u_rf (
    .clk(clk), .we(we), .waddr(wa), .wdata(wd),
    .raddr_a(ra), .rdata_a(rd_a), .raddr_b(rb), .rdata_b(rd_b)
  );

  aes8_sbox u_sbox (.x(sb_in), .y(sb_out));

  aes8_mixbyte u_mix (.col(col_q), .row(jj), .y(mix_out));

  // Address and operand selection; row rotation comes from the read order.
  always_comb begin
    we    = 1'b0;
    wa    = '0;
    wd    = 8'h00;
    ra    = '0;
    rb    = '0;
    sb_in = rd_a;
    opb   = rd_b;
    case (phase)
      PH_IDLE: begin
        if (din_valid && !start) begin
          we = 1'b1;
          wa = {key_sel, ptr_sel[1:0], ptr_sel[3:2]};
          wd = din;
        end
      end
      PH_ARK: begin
        ra = {1'b0, cnt[3:0]};
        rb = {1'b1, cnt[3:0]};
        we = 1'b1;
        wa = ra;
        wd = xo;
      end
      PH_KEY: begin
        ra = {1'b1, cnt[1:0], cnt[3:2]};
        if (cnt[3:2] == 2'd0) begin
          rb    = {1'b1, cnt[1:0] + 2'd1, 2'd3};
          sb_in = rd_b;
          opb   = sb_out ^ ((cnt[1:0] == 2'd0) ? rcon : 8'h00);
        end else begin
          rb = {1'b1, cnt[1:0], cnt[3:2] - 2'd1};
        end
        we = 1'b1;
        wa = ra;
        wd = xo;
      end
      PH_SUB: begin
        if (!half) begin
          ra = {1'b0, grp, jj + grp};
        end else begin
          we = 1'b1;
          wa = {1'b0, grp, jj};
          wd = col_q[8*jj +: 8];
        end
      end
      PH_MIX: begin
        if (!half) begin
          ra = {1'b0, jj, grp};
        end else begin
          we = 1'b1;
          wa = {1'b0, jj, grp};
          wd = mix_out;
        end
      end
      PH_OUT: begin
        ra = {1'b0, cnt[1:0], cnt[3:2]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (phase == PH_SUB && !half) col_q[8*jj +: 8] <= sb_out;
    if (phase == PH_MIX && !half) col_q[8*jj +: 8] <= rd_a;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      rnd        <= '0;
      rcon       <= 8'h01;
      ptr_key    <= '0;
      ptr_dat    <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      dout_valid <= 1'b0;
      dout       <= 8'h00;
    end else begin
      done       <= 1'b0;
      dout_valid <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_ARK;
            cnt     <= '0;
            rnd     <= '0;
            rcon    <= 8'h01;
            ptr_key <= '0;
            ptr_dat <= '0;
            busy    <= 1'b1;
          end else if (din_valid) begin
            if (key_sel) ptr_key <= ptr_key + 1'b1;
            else         ptr_dat <= ptr_dat + 1'b1;
          end
        end
        PH_ARK: begin
          if (cnt[3:0] == 4'hf) begin
            cnt <= '0;
            if (rnd == LAST_RND) phase <= PH_OUT;
            else begin
              rnd   <= rnd + 1'b1;
              phase <= PH_KEY;
            end
          end else cnt <= cnt + 5'd1;
        end
        PH_KEY: begin
          if (cnt[3:0] == 4'hf) begin
            cnt   <= '0;
            rcon  <= xtime(rcon);
            phase <= PH_SUB;
          end else cnt <= cnt + 5'd1;
        end
        PH_SUB: begin
          if (cnt == 5'd31) begin
            cnt   <= '0;
            phase <= (rnd == LAST_RND) ? PH_ARK : PH_MIX;
          end else cnt <= cnt + 5'd1;
        end
        PH_MIX: begin
          if (cnt == 5'd31) begin
            cnt   <= '0;
            phase <= PH_ARK;
          end else cnt <= cnt + 5'd1;
        end
        PH_OUT: begin
          dout       <= rd_a;
          dout_valid <= 1'b1;
          if (cnt[3:0] == 4'hf) begin
            cnt   <= '0;
            phase <= PH_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end else cnt <= cnt + 5'd1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6: done only together with the final output byte
  a_r6_done_with_byte: assert property (@(posedge clk) disable iff (rst) done |-> dout_valid);
  // R6: busy drops only with done
  a_r6_busy_fall_done: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);
  // R6: output stream ends right after done
  a_r6_stream_end: assert property (@(posedge clk) disable iff (rst) $fell(dout_valid) |-> $past(done));
  // R5: output bytes other than the last come while busy
  a_r5_valid_busy: assert property (@(posedge clk) disable iff (rst) (dout_valid && !done) |-> busy);
  // R7: round counter never passes the round count
  a_r7_round_limit: assert property (@(posedge clk) disable iff (rst) rnd <= LAST_RND);

endmodule

// File: tb/aes8_enc_core_tb.sv
`timescale 1ns/1ps
module aes8_enc_core_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] din = 8'h00;
  logic       din_valid = 1'b0;
  logic       key_sel = 1'b0;
  logic [7:0] dout;
  logic       dout_valid, busy, done;

  int checks = 0;
  int fails  = 0;
  logic [127:0] expq[$];
  logic [127:0] wkey;
  logic [127:0] got;
  int nb = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  aes8_enc_core u_dut (
    .clk(clk), .rst(rst), .start(start), .din(din), .din_valid(din_valid),
    .key_sel(key_sel), .dout(dout), .dout_valid(dout_valid), .busy(busy), .done(done)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  function automatic logic [7:0] m_xt(input logic [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = m_xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] m_sbox(input logic [7:0] v);
    logic [7:0] inv = 0;
    logic [7:0] c = 8'h63;
    logic [7:0] r;
    for (int y = 1; y < 256; y++)
      if (v != 0 && m_mul(v, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ c[i];
    return r;
  endfunction

  task automatic aes_ref(input logic [127:0] key, input logic [127:0] pt,
                         output logic [127:0] ct, output logic [127:0] rk);
    logic [7:0] s[16], k[16], t[16];
    logic [7:0] rc = 8'h01;
    logic [7:0] t0, t1, t2, t3;
    for (int n = 0; n < 16; n++) begin
      s[n] = pt[127-8*n -: 8];
      k[n] = key[127-8*n -: 8];
      s[n] ^= k[n];
    end
    for (int r = 1; r <= 10; r++) begin
      t0 = m_sbox(k[13]) ^ rc; t1 = m_sbox(k[14]);
      t2 = m_sbox(k[15]);      t3 = m_sbox(k[12]);
      k[0] ^= t0; k[1] ^= t1; k[2] ^= t2; k[3] ^= t3;
      for (int i = 4; i < 16; i++) k[i] ^= k[i-4];
      rc = m_xt(rc);
      for (int n = 0; n < 16; n++) s[n] = m_sbox(s[n]);
      for (int rw = 0; rw < 4; rw++)
        for (int c = 0; c < 4; c++) t[rw+4*c] = s[rw+4*((c+rw)%4)];
      for (int n = 0; n < 16; n++) s[n] = t[n];
      if (r < 10)
        for (int c = 0; c < 4; c++)
          for (int j = 0; j < 4; j++)
            s[4*c+j] = m_mul(t[4*c+j], 8'h02) ^ m_mul(t[4*c+(j+1)%4], 8'h03) ^
                       t[4*c+(j+2)%4] ^ t[4*c+(j+3)%4];
      for (int n = 0; n < 16; n++) s[n] ^= k[n];
    end
    for (int n = 0; n < 16; n++) begin
      ct[127-8*n -: 8] = s[n];
      rk[127-8*n -: 8] = k[n];
    end
  endtask

  // ---------------- driver ----------------
  task automatic load_block(input logic sel, input logic [127:0] v);
    for (int n = 0; n < 16; n++) begin
      @(negedge clk);
      key_sel   = sel;
      din       = v[127-8*n -: 8];
      din_valid = 1'b1;
    end
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  task automatic run_enc(input string tag, input logic [127:0] k, input logic [127:0] p,
                         input bit ld_key, input bit flood);
    logic [127:0] c, rk;
    int n;
    if (ld_key) begin
      load_block(1'b1, k);
      wkey = k;
    end
    load_block(1'b0, p);
    aes_ref(wkey, p, c, rk);
    expq.push_back(c);
    wkey = rk;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    check("R5 busy after start", 128'(busy), 128'(1));
    n = 0;
    while (!dout_valid) begin
      if (flood) begin
        din_valid = 1'b1;
        din       = 8'($urandom);
        key_sel   = 1'($urandom);
        start     = 1'($urandom);
      end
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    din_valid = 1'b0;
    start     = 1'b0;
    check({"R7 latency ", tag}, 128'(n), 128'(945));
    while (busy) @(negedge clk);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // ---------------- monitor / scoreboard ----------------
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done && !dout_valid) begin
        checks++; fails++;
        $display("FAIL R6 done without byte actual=1 expected=0");
      end
      if (dout_valid) begin
        got = {got[119:0], dout};
        nb++;
        if (nb == 16) begin
          nb = 0;
          check("R6 done on byte 15", 128'(done), 128'(1));
          if (expq.size() == 0) begin
            checks++; fails++;
            $display("FAIL R4 unexpected block actual=%h expected=none", got);
          end else check("R3/R4 ciphertext", got, expq.pop_front());
        end else if (done) begin
          checks++; fails++;
          $display("FAIL R6 early done actual=%0d expected=16", nb);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 busy", 128'(busy), 128'(0));
    check("R1 done", 128'(done), 128'(0));
    check("R1 dout_valid", 128'(dout_valid), 128'(0));

    // R3: standard vector
    run_enc("R3", 128'h000102030405060708090a0b0c0d0e0f,
            128'h00112233445566778899aabbccddeeff, 1'b1, 1'b0);
    if (wkey !== 128'h0) ; // working key tracked for R8

    // R4: random vectors
    for (int i = 0; i < 4; i++) run_enc("R4", rnd128(), rnd128(), 1'b1, 1'b0);

    // R8: reuse the leftover tenth round key
    run_enc("R8", 128'h0, rnd128(), 1'b0, 1'b0);

    // R5: inputs flooded while busy, then a clean run checks pointers
    run_enc("R5 flood", rnd128(), rnd128(), 1'b1, 1'b1);
    run_enc("R5 after", rnd128(), rnd128(), 1'b1, 1'b0);

    // R2: extra plaintext block wraps the counter; the second block wins
    load_block(1'b0, rnd128());
    run_enc("R2 wrap", rnd128(), rnd128(), 1'b1, 1'b0);

    repeat (4) @(negedge clk);
    check("R4 queue drained", 128'(expq.size()), 128'(0));
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule